// File: doc/BRIEF.md
# JTAG Vector Shift Engine

This block takes framed commands from a byte stream, such as the output of a UART receiver, and turns each one into a complete JTAG scan. A command names an opcode and a bit count, and then carries the TMS and TDI bit streams as interleaved bytes. The engine stores the whole command locally before it starts, so a scan is never cut across transfers. It then clocks TCK exactly once per bit, presenting TMS and TDI and capturing TDO on each cycle. At the end it parks the pins and streams back a reply frame that carries the captured TDO bits.

The engine has no TAP controller of its own. The host walks the TAP state machine purely through the TMS stream, so any mix of state moves and data shifts fits in one transaction. The TCK rate is set by a half-period divider input. The reply is handed out under a valid/ready handshake, and a busy flag covers the whole transaction.

Top module: `jtagVecEngine`

## Requirements
- R1: A command starts with an opcode byte followed by the 16-bit bit count, high byte first. The reply begins with three header bytes: the opcode, then the executed bit count high byte, then its low byte.
- R2: Each stream carries ceil(count/8) bytes, and an exact multiple of 8 adds no extra byte. The payload alternates by byte index: the TMS byte k comes first, then the TDI byte k.
- R3: Sequence bit i is bit (i mod 8) of byte i/8, so the least significant bit goes first. TMS and TDI change only while TCK is low and hold steady across each rising TCK edge.
- R4: A command of N bits produces exactly N rising TCK edges that carry data, plus one final return-high edge. TDO is sampled on each data rising edge.
- R5: TCK high and TCK low each last halfDiv+1 clock cycles, so successive data rising edges are 2*(halfDiv+1) cycles apart.
- R6: After the last bit, TCK, TMS and TDI are driven low for one half-period. TCK then returns high while TMS and TDI stay low, and this state holds when the first reply byte is offered.
- R7: After the header, the reply carries the TDO bits packed least significant bit first, in ceil(count/8) bytes, with the unused high bits of the last byte zero.
- R8: A reply byte transfers on a clock where outValid and outReady are both high. While outValid is high and outReady is low, outValid and outData hold steady.
- R9: A bit count of zero produces a reply of the header only, with no TCK edges.
- R10: A bit count above MAX_BITS (default 4096) is saturated to MAX_BITS. The saturated value sets the payload length, the number of bits shifted and the echoed count.
- R11: busy is high from the clock after the first header byte is accepted until the clock after the last reply byte transfers, and it is low otherwise.
- R12: Input bytes that arrive while the engine is shifting or replying are ignored. The reply and the next command are unaffected.
- R13: After reset, TCK is high, TMS and TDI are low, and busy and outValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte strobe |
| inData | input | 8 | Input byte |
| halfDiv | input | 8 | TCK half-period minus one, in clock cycles |
| outValid | output | 1 | Reply byte available |
| outReady | input | 1 | Reply byte accepted by the sink |
| outData | output | 8 | Reply byte |
| busy | output | 1 | Transaction in progress |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
If the bit or payload counters are wrong, the fault shows at the very next rising TCK edge: TMS or TDI differs from the host's stream bit, or the pulse count goes one over or one under. A wrong TDO packing index or a stale accumulator shows in the reply bytes within one frame, and a mistake in the rounding of the byte count shows as a reply that is one byte too long or too short. A mistake in the divider or the control state shows as a change in the spacing between rising edges, or in busy on the cycle where it occurs.

// File: rtl/jve_pkg.sv
package jve_pkg;
  typedef struct packed {
    logic capOp;
    logic capHi;
    logic capLo;
    logic capPay;
    logic startBit;
    logic fallEdge;
    logic riseEdge;
    logic park;
    logic unpark;
    logic startReply;
    logic nextReply;
  } jveStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR1, S_HDR2, S_LOAD, S_LOW, S_HIGH, S_PARK, S_REPLY
  } jveState_t;
endpackage

// File: rtl/jveDatapath.sv
module jveDatapath
  import jve_pkg::*;
#(
  parameter int MAX_BITS = 4096,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  jveStrobe_t       st,
  input  logic [7:0]       inData,
  input  logic             tdo,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  output logic [7:0]       outData,
  output logic             payDone,
  output logic             bitsDone,
  output logic             bitsZero,
  output logic             replyLast
);
  localparam int MAX_BYTES = (MAX_BITS + 7) / 8;
  localparam int AW        = $clog2(MAX_BYTES);

  logic [7:0]       tmsMem [MAX_BYTES];
  logic [7:0]       tdiMem [MAX_BYTES];
  logic [7:0]       tdoMem [MAX_BYTES];
  logic [7:0]       opReg, hiReg, tdoAcc, accNext;
  logic [CNT_W-1:0] bitsReg, bitIdx, repIdx, nBytes, rawCount;
  logic [CNT_W:0]   payIdx;
  logic [AW-1:0]    rdByte;
  logic [2:0]       rdBit;

  // per-stream byte count, rounded up without an extra byte on exact multiples
  assign nBytes    = (bitsReg >> 3) + CNT_W'(|bitsReg[2:0]);
  assign payDone   = (payIdx == {nBytes, 1'b0});
  assign bitsDone  = (bitIdx == bitsReg);
  assign bitsZero  = (bitsReg == '0);
  assign replyLast = (repIdx == nBytes + CNT_W'(2));
  assign rawCount  = {hiReg, inData};

  assign rdByte = st.startBit ? '0 : bitIdx[AW+2:3];
  assign rdBit  = st.startBit ? 3'd0 : bitIdx[2:0];

  always_comb begin
    accNext = tdoAcc;
    accNext[bitIdx[2:0]] = tdo;
  end

  // header and counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= '0;
      hiReg   <= '0;
      bitsReg <= '0;
      payIdx  <= '0;
      bitIdx  <= '0;
      repIdx  <= '0;
      tdoAcc  <= '0;
    end else begin
      if (st.capOp) opReg <= inData;
      if (st.capHi) hiReg <= inData;
      if (st.capLo) begin
        bitsReg <= (rawCount > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : rawCount;
        payIdx  <= '0;
      end
      if (st.capPay) payIdx <= payIdx + 1'b1;
      if (st.startBit) begin
        bitIdx <= '0;
        tdoAcc <= '0;
      end
      if (st.riseEdge) begin
        bitIdx <= bitIdx + 1'b1;
        tdoAcc <= (bitIdx[2:0] == 3'd7) ? 8'h00 : accNext;
      end
      if (st.startReply) repIdx <= '0;
      if (st.nextReply)  repIdx <= repIdx + 1'b1;
    end
  end

  // pin drivers: change on falling TCK, hold through rising TCK
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tck <= 1'b1;
      tms <= 1'b0;
      tdi <= 1'b0;
    end else begin
      if (st.fallEdge) begin
        tck <= 1'b0;
        tms <= tmsMem[rdByte][rdBit];
        tdi <= tdiMem[rdByte][rdBit];
      end
      if (st.riseEdge) tck <= 1'b1;
      if (st.park) begin
        tck <= 1'b0;
        tms <= 1'b0;
        tdi <= 1'b0;
      end
      if (st.unpark) tck <= 1'b1;
    end
  end

  // command and capture storage
  always_ff @(posedge clk) begin
    if (st.capPay) begin
      if (!payIdx[0]) tmsMem[payIdx[AW:1]] <= inData;
      else            tdiMem[payIdx[AW:1]] <= inData;
    end
    if (st.riseEdge && (bitIdx[2:0] == 3'd7 || (bitIdx + CNT_W'(1)) == bitsReg))
      tdoMem[bitIdx[AW+2:3]] <= accNext;
  end

  always_comb begin
    case (repIdx)
      CNT_W'(0): outData = opReg;
      CNT_W'(1): outData = bitsReg[15:8];
      CNT_W'(2): outData = bitsReg[7:0];
      default:   outData = tdoMem[AW'(repIdx - CNT_W'(3))];
    endcase
  end

  assert_pay_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.capPay |-> (payIdx < {nBytes, 1'b0}));
  assert_no_extra_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    st.riseEdge |-> (bitIdx < bitsReg));
  assert_pins_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));
  assert_zero_no_clock_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.fallEdge |-> !bitsZero);
endmodule

// File: rtl/jveControl.sv
module jveControl
  import jve_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             payDone,
  input  logic             bitsDone,
  input  logic             bitsZero,
  input  logic             replyLast,
  output jveStrobe_t       st,
  output logic             outValid,
  output logic             busy
);
  jveState_t        state, nxt;
  logic [DIV_W-1:0] halfCnt;
  logic             cntClr, halfEnd;

  assign halfEnd  = (halfCnt == halfDiv);
  assign outValid = (state == S_REPLY);
  assign busy     = (state != S_IDLE);

  always_comb begin
    st     = '0;
    nxt    = state;
    cntClr = 1'b0;
    case (state)
      S_IDLE: if (inValid) begin st.capOp = 1'b1; nxt = S_HDR1; end
      S_HDR1: if (inValid) begin st.capHi = 1'b1; nxt = S_HDR2; end
      S_HDR2: if (inValid) begin st.capLo = 1'b1; nxt = S_LOAD; end
      S_LOAD: begin
        if (payDone) begin
          cntClr = 1'b1;
          if (bitsZero) begin
            st.startReply = 1'b1;
            nxt = S_REPLY;
          end else begin
            st.startBit = 1'b1;
            st.fallEdge = 1'b1;
            nxt = S_LOW;
          end
        end else if (inValid) begin
          st.capPay = 1'b1;
        end
      end
      S_LOW: if (halfEnd) begin
        st.riseEdge = 1'b1;
        cntClr = 1'b1;
        nxt = S_HIGH;
      end
      S_HIGH: if (halfEnd) begin
        cntClr = 1'b1;
        if (bitsDone) begin
          st.park = 1'b1;
          nxt = S_PARK;
        end else begin
          st.fallEdge = 1'b1;
          nxt = S_LOW;
        end
      end
      S_PARK: if (halfEnd) begin
        st.unpark = 1'b1;
        st.startReply = 1'b1;
        cntClr = 1'b1;
        nxt = S_REPLY;
      end
      S_REPLY: if (outReady) begin
        st.nextReply = 1'b1;
        if (replyLast) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      halfCnt <= '0;
    end else begin
      state   <= nxt;
      halfCnt <= cntClr ? '0 : halfCnt + 1'b1;
    end
  end

  assert_busy_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(outValid && outReady));
  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/jtagVecEngine.sv
module jtagVecEngine
  import jve_pkg::*;
#(
  parameter int MAX_BITS = 4096,
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             busy,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo
);
  jveStrobe_t st;
  logic       payDone, bitsDone, bitsZero, replyLast;

  jveControl #(.DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .halfDiv(halfDiv), .payDone(payDone), .bitsDone(bitsDone),
    .bitsZero(bitsZero), .replyLast(replyLast), .st(st),
    .outValid(outValid), .busy(busy)
  );

  jveDatapath #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .outData(outData),
    .payDone(payDone), .bitsDone(bitsDone), .bitsZero(bitsZero),
    .replyLast(replyLast)
  );

  assert_reply_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));
endmodule

// File: tb/test_jtagVecEngine.sv
module test_jtagVecEngine;
  localparam int MAXB = 4096;

  logic       clk = 1'b0, rstN = 1'b0, inValid = 1'b0, outReady = 1'b0, tdo = 1'b0;
  logic [7:0] inData = '0, halfDiv = '0, outData;
  logic       outValid, busy, tck, tms, tdi;

  jtagVecEngine i_jtagVecEngine (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .halfDiv(halfDiv),
    .outValid(outValid), .outReady(outReady), .outData(outData), .busy(busy),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  always #2.5 clk = ~clk;

  int  vectors = 0, miscompares = 0, cyc = 0;
  int  expBits = 0, riseCount = 0, fallCount = 0, lastRise = 0, curDiv = 0;
  bit  armed = 0, expBusy = 0, dropPending = 0;
  bit  expTms [MAXB], expTdi [MAXB], tdoPat [MAXB + 8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // busy compared with the model on every clock (R11)
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      check(busy == expBusy, "R11 busy", busy, expBusy);
      if (dropPending) begin
        expBusy = 0;
        dropPending = 0;
      end
    end
  end

  always @(posedge tck) if (armed) begin
    if (riseCount < expBits) begin
      check(tms == expTms[riseCount], "R3 tms", tms, expTms[riseCount]);
      check(tdi == expTdi[riseCount], "R3 tdi", tdi, expTdi[riseCount]);
      if (riseCount > 0)
        check(cyc - lastRise == 2 * (curDiv + 1), "R5 period", cyc - lastRise, 2 * (curDiv + 1));
    end else begin
      check(!tms && !tdi, "R6 park pins", {tms, tdi}, 0);
      check(cyc - lastRise == 2 * (curDiv + 1), "R6 park length", cyc - lastRise, 2 * (curDiv + 1));
    end
    lastRise = cyc;
    riseCount++;
  end

  // target model: TDO updates on falling TCK
  always @(negedge tck) if (armed) begin
    tdo = tdoPat[fallCount];
    fallCount++;
  end

  task automatic sendByte(input logic [7:0] b, input int gap);
    inValid = 1'b1;
    inData  = b;
    @(negedge clk);
    inValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic runCmd(input logic [7:0] op, input int req, input int div,
                        input int gapMax, input bit randReady, input bit stray);
    int nb, idx, nRep;
    logic [7:0] b, expRep [MAXB / 4 + 3];
    expBits = (req > MAXB) ? MAXB : req;
    nb = (expBits + 7) / 8;
    curDiv = div;
    halfDiv = 8'(div);
    for (int i = 0; i < MAXB; i++) begin
      expTms[i] = 1'($urandom);
      expTdi[i] = 1'($urandom);
      tdoPat[i] = 1'($urandom);
    end
    riseCount = 0;
    fallCount = 0;
    armed = 1;
    sendByte(op, 0);
    expBusy = 1;
    repeat ($urandom_range(gapMax, 0)) @(negedge clk);
    sendByte(8'(req >> 8), $urandom_range(gapMax, 0));
    sendByte(8'(req), $urandom_range(gapMax, 0));
    for (int k = 0; k < nb; k++) begin
      for (int j = 0; j < 8; j++) b[j] = expTms[8 * k + j];
      sendByte(b, $urandom_range(gapMax, 0));
      for (int j = 0; j < 8; j++) b[j] = expTdi[8 * k + j];
      sendByte(b, $urandom_range(gapMax, 0));
    end
    if (stray) begin
      repeat (3) @(negedge clk);
      sendByte(8'h5A, 0);
    end
    expRep[0] = op;
    expRep[1] = 8'(expBits >> 8);
    expRep[2] = 8'(expBits);
    for (int k = 0; k < nb; k++)
      for (int j = 0; j < 8; j++)
        expRep[3 + k][j] = (8 * k + j < expBits) ? tdoPat[8 * k + j] : 1'b0;
    nRep = nb + 3;
    idx = 0;
    while (idx < nRep) begin
      @(negedge clk);
      outReady = randReady ? 1'($urandom) : 1'b1;
      if (outValid && outReady) begin
        if (idx == 0) check(tck && !tms && !tdi, "R6 idle pins", {tck, tms, tdi}, 3'b100);
        if (idx < 3)
          check(outData == expRep[idx], (req > MAXB) ? "R10 header" : "R1 header", outData, expRep[idx]);
        else
          check(outData == expRep[idx], "R7 tdo byte", outData, expRep[idx]);
        idx++;
      end
    end
    dropPending = 1;
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid, "R2 reply length", outValid, 0);
    if (expBits == 0) check(riseCount == 0 && fallCount == 0, "R9 no clock", riseCount + fallCount, 0);
    else check(riseCount == expBits + 1, "R4 rising edges", riseCount, expBits + 1);
    check(fallCount == ((expBits == 0) ? 0 : expBits + 1), "R4 falling edges", fallCount,
          (expBits == 0) ? 0 : expBits + 1);
    armed = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(tck && !tms && !tdi, "R13 pins", {tck, tms, tdi}, 3'b100);
    check(!busy && !outValid, "R13 flags", {busy, outValid}, 0);
    runCmd(8'h11, 13, 1, 2, 0, 0);
    runCmd(8'h22, 8, 0, 0, 0, 0);      // exact multiple, R2
    runCmd(8'h33, 9, 3, 1, 1, 1);      // backpressure R8, stray byte R12
    runCmd(8'h44, 1, 2, 0, 1, 0);
    runCmd(8'h55, 0, 1, 1, 1, 0);      // zero count R9
    runCmd(8'h66, 5000, 0, 0, 0, 1);   // saturation R10, stray byte R12
    runCmd(8'h77, 64, 1, 1, 1, 1);     // next command after strays, R12
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule